// File: doc/BRIEF.md
# Flash Command Sequencer

This block runs maintenance operations on a small on-chip nonvolatile word array. It sits behind a register port. A host loads an address register and a data register, then writes an operation code into the mode register. The sequencer captures the operands, holds a busy flag for the duration of that operation, and then applies the result to the array. It supports five operations: whole-array erase, single page erase, single word program, single word read, and a bulk transfer of the array into a byte-wide configuration RAM. The host polls bit 0 of the mode register and starts the next operation only once that bit reads 0.

The array is a behavioural model. Programming can only clear bits, so the new value is the old value ANDed with the written data, and every word must be erased before it takes arbitrary data. Each operation duration is a parameter counted in clock cycles. Erase and program need the conversion-running input at 0. A command that is refused leaves everything unchanged and raises a sticky error flag. Writing code 00h while idle clears that flag.

Top module: `fcmd_sequencer`

## Requirements
- R1: After reset the mode register reads 0000h, busy and cram_we are 0, the data-out register reads 0000h, and every array word reads back as FFFFh.
- R2: Mode register bit 0 equals busy and bit 1 is the sticky error flag; the other bits read 0. An accepted command raises busy on the edge that takes the write. Busy then stays high for exactly the operation's parameter count of cycles: T_PROG for code 20h, T_PAGE for 40h, T_MASS for 60h, T_READ for 80h, and 2*2^(PAGE_W+WORD_W) for A0h.
- R3: Code 20h replaces the addressed word with its old value AND the data-in register, so an erased word takes the data exactly.
- R4: Code 80h loads the addressed word into the data-out register (1Bh) by the time busy clears.
- R5: Code 40h sets every word of the page named by the upper PAGE_W address bits to FFFFh, whatever the lower WORD_W bits hold, and leaves other pages unchanged.
- R6: Code 60h sets every word of the array to FFFFh.
- R7: Code A0h asserts cram_we for 2*2^(PAGE_W+WORD_W) consecutive cycles with cram_addr counting up from 0. Each address 2n carries the high byte of word n and each address 2n+1 carries its low byte.
- R8: With conv_run at 1, codes 20h, 40h and 60h are refused: busy stays 0, the array is unchanged and the error flag is set. Codes 80h and A0h still run.
- R9: A mode write while busy, or any code other than 00h, 20h, 40h, 60h, 80h and A0h, is refused and sets the error flag without affecting the operation in progress. Writing 00h while idle clears the flag.
- R10: The address and data-in values are taken when a command is accepted. Writes to those registers while busy do not change the running operation.
- R11: The register map is mode 18h, address 19h (page bits above word bits), data-in 1Ah and data-out 1Bh. The address and data-in registers read back what was written. Data-out ignores writes, and unmapped addresses read 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on reg_addr |
| conv_run | input | 1 | Conversion running; blocks erase and program |
| busy | output | 1 | Operation in progress |
| cram_we | output | 1 | Configuration RAM write enable |
| cram_addr | output | PAGE_W+WORD_W+1 | Configuration RAM byte address |
| cram_wdata | output | 8 | Configuration RAM write byte |

## Verification
Program patterns are written first to erased words and then over programmed ones. The AND result separates a true bit-clearing model from a plain overwrite. Page erase is issued with a nonzero word field next to a programmed neighbour page. This shows whether the page decode uses the right bits and whether the word field is ignored. The transfer runs over distinct values in the high and low bytes of each word, which exposes byte swaps and address-step faults. Refused commands (while busy, with an unknown code, or with conversion running) are followed by read-back of the array and the mode register. This confirms that nothing changed except the error flag.

// File: rtl/fcmd_pkg.sv
`timescale 1ns/1ps
// Shared command codes, register offsets and controller states for the
// flash command sequencer. Assumes 8-bit register offsets.
package fcmd_pkg;
    localparam logic [7:0] OP_NONE = 8'h00;
    localparam logic [7:0] OP_PROG = 8'h20;
    localparam logic [7:0] OP_PAGE = 8'h40;
    localparam logic [7:0] OP_MASS = 8'h60;
    localparam logic [7:0] OP_READ = 8'h80;
    localparam logic [7:0] OP_COPY = 8'hA0;

    localparam logic [7:0] RA_MODE = 8'h18;
    localparam logic [7:0] RA_ADDR = 8'h19;
    localparam logic [7:0] RA_DIN  = 8'h1A;
    localparam logic [7:0] RA_DOUT = 8'h1B;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_COPY
    } st_e;
endpackage

// File: rtl/fcmd_timer.sv
`timescale 1ns/1ps
// Loadable down-counter that times one operation.
// Assumes load and run are never high together.
module fcmd_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Count down from the loaded value while the operation runs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Signal the final cycle of the timed window.
    always_comb done = run && (cnt_q == '0);
endmodule

// File: rtl/fcmd_array.sv
`timescale 1ns/1ps
// Behavioural nonvolatile word array. Erase sets words to all ones and
// program ANDs new data in. Reset models an erased array. Assumes at most
// one of the operation strobes is high in a cycle.
module fcmd_array #(
    parameter int PAGE_W = 3,
    parameter int WORD_W = 3,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     do_mass,
    input  logic                     do_page,
    input  logic                     do_prog,
    input  logic [PAGE_W+WORD_W-1:0] op_addr,
    input  logic [DATA_W-1:0]        op_data,
    input  logic [PAGE_W+WORD_W-1:0] rd_addr,
    output logic [DATA_W-1:0]        rd_data
);
    localparam int AW = PAGE_W + WORD_W;
    localparam int NW = 1 << AW;

    logic [DATA_W-1:0] words [NW];

    for (genvar i = 0; i < NW; i++) begin : g_word
        localparam logic [AW-1:0] IA = AW'(i);
        logic page_hit;
        always_comb page_hit = (op_addr[AW-1:WORD_W] == IA[AW-1:WORD_W]);

        // Apply erase or program to this word when it is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[i] <= '1;
            else if (do_mass || (do_page && page_hit))
                words[i] <= '1;
            else if (do_prog && op_addr == IA)
                words[i] <= words[i] & op_data;
        end
    end

    // Asynchronous read of the selected word.
    always_comb rd_data = words[rd_addr];
endmodule

// File: rtl/fcmd_ctrl.sv
`timescale 1ns/1ps
// Command acceptance, operand capture, operation timing and the bulk
// transfer walk. Assumes cmd_wr is a one-cycle strobe per mode write.
module fcmd_ctrl
    import fcmd_pkg::*;
#(
    parameter int PAGE_W = 3,
    parameter int WORD_W = 3,
    parameter int DATA_W = 16,
    parameter int T_MASS = 64,
    parameter int T_PAGE = 24,
    parameter int T_PROG = 10,
    parameter int T_READ = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_wr,
    input  logic [7:0]               cmd_code,
    input  logic                     conv_run,
    input  logic [PAGE_W+WORD_W-1:0] addr_in,
    input  logic [DATA_W-1:0]        data_in,
    output logic                     busy,
    output logic                     err,
    output logic                     do_mass,
    output logic                     do_page,
    output logic                     do_prog,
    output logic                     rd_done,
    output logic [PAGE_W+WORD_W-1:0] op_addr,
    output logic [DATA_W-1:0]        op_data,
    output logic [PAGE_W+WORD_W-1:0] arr_raddr,
    output logic                     cram_we,
    output logic [PAGE_W+WORD_W:0]   cram_addr
);
    localparam int AW    = PAGE_W + WORD_W;
    localparam int CW    = AW + 1;
    localparam int TM1   = (T_MASS > T_PAGE) ? T_MASS : T_PAGE;
    localparam int TM2   = (T_PROG > T_READ) ? T_PROG : T_READ;
    localparam int TMAX  = (TM1 > TM2) ? TM1 : TM2;
    localparam int CNT_W = $clog2(TMAX + 1);
    localparam logic [CW-1:0] LAST_IDX = {CW{1'b1}};

    st_e              st_q;
    logic [7:0]       op_q;
    logic [CW-1:0]    idx_q;
    logic             legal, guarded, accept, clear, refuse, is_copy;
    logic [CNT_W-1:0] dur;
    logic             t_done;

    // Classify the written code and decide whether it starts, clears or is refused.
    always_comb begin
        legal   = (cmd_code == OP_PROG) || (cmd_code == OP_PAGE) ||
                  (cmd_code == OP_MASS) || (cmd_code == OP_READ) ||
                  (cmd_code == OP_COPY);
        guarded = (cmd_code == OP_PROG) || (cmd_code == OP_PAGE) ||
                  (cmd_code == OP_MASS);
        is_copy = (cmd_code == OP_COPY);
        accept  = cmd_wr && (st_q == ST_IDLE) && legal && !(guarded && conv_run);
        clear   = cmd_wr && (st_q == ST_IDLE) && (cmd_code == OP_NONE);
        refuse  = cmd_wr && !accept && !clear;
    end

    // Pick the timer preload for the written code.
    always_comb begin
        case (cmd_code)
            OP_MASS: dur = CNT_W'(T_MASS - 1);
            OP_PAGE: dur = CNT_W'(T_PAGE - 1);
            OP_PROG: dur = CNT_W'(T_PROG - 1);
            default: dur = CNT_W'(T_READ - 1);
        endcase
    end

    fcmd_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept && !is_copy),
        .load_val (dur),
        .run      (st_q == ST_RUN),
        .done     (t_done)
    );

    // Sequence state: idle, timed operation, or transfer walk.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else begin
            case (st_q)
                ST_IDLE: if (accept) st_q <= is_copy ? ST_COPY : ST_RUN;
                ST_RUN:  if (t_done) st_q <= ST_IDLE;
                ST_COPY: if (idx_q == LAST_IDX) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the code and operands when a command is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_NONE;
            op_addr <= '0;
            op_data <= '0;
        end else if (accept) begin
            op_q    <= cmd_code;
            op_addr <= addr_in;
            op_data <= data_in;
        end
    end

    // Step the transfer byte index.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (accept)
            idx_q <= '0;
        else if (st_q == ST_COPY)
            idx_q <= idx_q + 1'b1;
    end

    // Sticky error flag: set on refusal, cleared by an idle no-op write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if (refuse)
            err <= 1'b1;
        else if (clear)
            err <= 1'b0;
    end

    // Completion strobes and transfer outputs.
    always_comb begin
        busy      = (st_q != ST_IDLE);
        do_mass   = t_done && (op_q == OP_MASS);
        do_page   = t_done && (op_q == OP_PAGE);
        do_prog   = t_done && (op_q == OP_PROG);
        rd_done   = t_done && (op_q == OP_READ);
        cram_we   = (st_q == ST_COPY);
        cram_addr = idx_q;
        arr_raddr = (st_q == ST_COPY) ? idx_q[CW-1:1] : op_addr;
    end
endmodule

// File: rtl/fcmd_sequencer.sv
`timescale 1ns/1ps
// Top of the flash command sequencer: host register file, read mux,
// controller and word array. Assumes 16-bit words split into two bytes.
module fcmd_sequencer
    import fcmd_pkg::*;
#(
    parameter int PAGE_W = 3,
    parameter int WORD_W = 3,
    parameter int T_MASS = 64,
    parameter int T_PAGE = 24,
    parameter int T_PROG = 10,
    parameter int T_READ = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [7:0]             reg_addr,
    input  logic [15:0]            reg_wdata,
    output logic [15:0]            reg_rdata,
    input  logic                   conv_run,
    output logic                   busy,
    output logic                   cram_we,
    output logic [PAGE_W+WORD_W:0] cram_addr,
    output logic [7:0]             cram_wdata
);
    localparam int AW     = PAGE_W + WORD_W;
    localparam int DATA_W = 16;

    logic [AW-1:0]     addr_r;
    logic [DATA_W-1:0] din_r, dout_r;
    logic              err_flag, do_mass, do_page, do_prog, rd_done;
    logic [AW-1:0]     op_addr, arr_raddr;
    logic [DATA_W-1:0] op_data, arr_rdata;
    logic              cmd_wr;

    always_comb cmd_wr = reg_wr && (reg_addr == RA_MODE);

    // Host-writable operand registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_r <= '0;
            din_r  <= '0;
        end else if (reg_wr) begin
            if (reg_addr == RA_ADDR) addr_r <= reg_wdata[AW-1:0];
            if (reg_addr == RA_DIN)  din_r  <= reg_wdata;
        end
    end

    // Data-out register, loaded only by a completed read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout_r <= '0;
        else if (rd_done)
            dout_r <= arr_rdata;
    end

    // Register read mux.
    always_comb begin
        case (reg_addr)
            RA_MODE: reg_rdata = {14'b0, err_flag, busy};
            RA_ADDR: reg_rdata = {{(16-AW){1'b0}}, addr_r};
            RA_DIN:  reg_rdata = din_r;
            RA_DOUT: reg_rdata = dout_r;
            default: reg_rdata = '0;
        endcase
    end

    fcmd_ctrl #(
        .PAGE_W(PAGE_W), .WORD_W(WORD_W), .DATA_W(DATA_W),
        .T_MASS(T_MASS), .T_PAGE(T_PAGE), .T_PROG(T_PROG), .T_READ(T_READ)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_code  (reg_wdata[7:0]),
        .conv_run  (conv_run),
        .addr_in   (addr_r),
        .data_in   (din_r),
        .busy      (busy),
        .err       (err_flag),
        .do_mass   (do_mass),
        .do_page   (do_page),
        .do_prog   (do_prog),
        .rd_done   (rd_done),
        .op_addr   (op_addr),
        .op_data   (op_data),
        .arr_raddr (arr_raddr),
        .cram_we   (cram_we),
        .cram_addr (cram_addr)
    );

    fcmd_array #(.PAGE_W(PAGE_W), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .do_mass (do_mass),
        .do_page (do_page),
        .do_prog (do_prog),
        .op_addr (op_addr),
        .op_data (op_data),
        .rd_addr (arr_raddr),
        .rd_data (arr_rdata)
    );

    // Even byte addresses carry the high byte, odd ones the low byte.
    always_comb cram_wdata = cram_addr[0] ? arr_rdata[7:0] : arr_rdata[15:8];
endmodule

// File: rtl/fcmd_sequencer_chk.sv
`timescale 1ns/1ps
// Protocol checks for the flash command sequencer, bound to the top.
module fcmd_sequencer_chk
    import fcmd_pkg::*;
#(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [7:0]    reg_addr,
    input logic [7:0]    code,
    input logic          conv_run,
    input logic          busy,
    input logic          err,
    input logic          cram_we,
    input logic [AW:0]   cram_addr
);
    localparam int NB = 2 << AW;
    logic [AW+1:0] we_run;
    logic          mode_wr;

    always_comb mode_wr = reg_wr && (reg_addr == RA_MODE);

    // Length of the current transfer burst.
    always_ff @(posedge clk) begin
        if (!rst_n)
            we_run <= '0;
        else if (cram_we)
            we_run <= we_run + 1'b1;
        else
            we_run <= '0;
    end

    // R2
    start_by_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(mode_wr));

    // R8
    conv_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !busy && conv_run &&
         (code == OP_PROG || code == OP_PAGE || code == OP_MASS)) |=> (!busy && err));

    // R9
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && busy) |=> (err && busy));

    // R7
    cram_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cram_we |-> busy);

    // R7
    cram_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cram_we) |-> (cram_addr == '0));

    // R7
    cram_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cram_we && $past(cram_we)) |-> (cram_addr == $past(cram_addr) + 1'b1));

    // R7
    cram_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cram_we) |-> (we_run == (AW+2)'(NB)));
endmodule

bind fcmd_sequencer fcmd_sequencer_chk #(.AW(PAGE_W + WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .code      (reg_wdata[7:0]),
    .conv_run  (conv_run),
    .busy      (busy),
    .err       (err_flag),
    .cram_we   (cram_we),
    .cram_addr (cram_addr)
);

// File: tb/sim_fcmd_sequencer.sv
`timescale 1ns/1ps
// Directed bench for the flash command sequencer.
module sim_fcmd_sequencer;
    localparam int PAGE_W = 3;
    localparam int WORD_W = 3;
    localparam int AW     = PAGE_W + WORD_W;
    localparam int NW     = 1 << AW;
    localparam int T_MASS = 64;
    localparam int T_PAGE = 24;
    localparam int T_PROG = 10;
    localparam int T_READ = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_addr = 8'h00;
    logic [15:0]   reg_wdata = 16'h0000;
    logic [15:0]   reg_rdata;
    logic          conv_run = 1'b0;
    logic          busy, cram_we;
    logic [AW:0]   cram_addr;
    logic [7:0]    cram_wdata;

    int vectors = 0;
    int fails   = 0;
    logic [15:0] model [NW];

    always #2.5 clk = ~clk;

    fcmd_sequencer #(
        .PAGE_W(PAGE_W), .WORD_W(WORD_W),
        .T_MASS(T_MASS), .T_PAGE(T_PAGE), .T_PROG(T_PROG), .T_READ(T_READ)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_run(conv_run),
        .busy(busy), .cram_we(cram_we), .cram_addr(cram_addr), .cram_wdata(cram_wdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the write edge.
    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic cmd(input logic [7:0] code, output int n);
        wr(8'h18, {8'h00, code});
        wait_idle(n);
    endtask

    task automatic read_word(input logic [AW-1:0] a, output logic [15:0] d);
        int n;
        wr(8'h19, 16'(a));
        cmd(8'h80, n);
        rd(8'h1B, d);
    endtask

    task automatic prog_word(input logic [AW-1:0] a, input logic [15:0] d, output int n);
        wr(8'h19, 16'(a));
        wr(8'h1A, d);
        cmd(8'h20, n);
        model[a] = model[a] & d;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rd(8'h18, d); chk("R1 mode after reset", d, 16'h0000);
        chk("R1 busy after reset", busy, 1'b0);
        chk("R1 cram_we after reset", cram_we, 1'b0);
        rd(8'h1B, d); chk("R1 data-out after reset", d, 16'h0000);
        read_word(6'd5, d); chk("R1 erased word", d, 16'hFFFF);
        read_word(6'd63, d); chk("R1 erased last word", d, 16'hFFFF);
    endtask

    task automatic t_prog_read();
        logic [15:0] d;
        int n;
        wr(8'h19, 16'd19);
        wr(8'h1A, 16'hA5C3);
        wr(8'h18, 16'h0020);
        rd(8'h18, d); chk("R2 busy bit during program", d[0], 1'b1);
        wait_idle(n); chk("R2 program duration", n, T_PROG);
        model[19] = 16'hA5C3;
        wr(8'h18, 16'h0080);
        wait_idle(n); chk("R2 read duration", n, T_READ);
        rd(8'h1B, d); chk("R4 read of programmed word", d, 16'hA5C3);
        prog_word(6'd19, 16'h0F0F, n);
        read_word(6'd19, d); chk("R3 program ANDs into old value", d, 16'h0503);
        prog_word(6'd20, 16'h1234, n);
        read_word(6'd20, d); chk("R3 program into erased word", d, 16'h1234);
    endtask

    task automatic t_page();
        logic [15:0] d;
        int n;
        prog_word(6'd24, 16'h00FF, n);
        prog_word(6'd31, 16'hBEEF, n);
        wr(8'h19, 16'd21);
        cmd(8'h40, n); chk("R2 page erase duration", n, T_PAGE);
        for (int i = 16; i < 24; i++) model[i] = 16'hFFFF;
        read_word(6'd19, d); chk("R5 page word erased", d, 16'hFFFF);
        read_word(6'd20, d); chk("R5 page word erased", d, 16'hFFFF);
        read_word(6'd24, d); chk("R5 next page untouched", d, 16'h00FF);
        read_word(6'd31, d); chk("R5 next page untouched", d, 16'hBEEF);
    endtask

    task automatic t_capture();
        logic [15:0] d;
        int n;
        wr(8'h19, 16'd40);
        wr(8'h1A, 16'h6789);
        wr(8'h18, 16'h0020);
        wr(8'h19, 16'd41);
        wr(8'h1A, 16'h0000);
        wait_idle(n);
        model[40] = 16'h6789;
        read_word(6'd40, d); chk("R10 operands captured at start", d, 16'h6789);
        read_word(6'd41, d); chk("R10 later address not programmed", d, 16'hFFFF);
    endtask

    task automatic t_conv();
        logic [15:0] d;
        int n;
        conv_run = 1'b1;
        wr(8'h19, 16'd50);
        wr(8'h1A, 16'h0000);
        wr(8'h18, 16'h0020);
        chk("R8 program refused, busy", busy, 1'b0);
        rd(8'h18, d); chk("R8 error flag set", d, 16'h0002);
        wr(8'h18, 16'h0060);
        chk("R8 mass erase refused, busy", busy, 1'b0);
        read_word(6'd50, d); chk("R8 read runs with conversion, word unchanged", d, 16'hFFFF);
        read_word(6'd24, d); chk("R8 no erase happened", d, 16'h00FF);
        conv_run = 1'b0;
        cmd(8'h00, n);
        rd(8'h18, d); chk("R9 no-op clears error", d, 16'h0000);
    endtask

    task automatic t_busy_cmd();
        logic [15:0] d;
        int n;
        wr(8'h19, 16'd24);
        wr(8'h18, 16'h0080);
        wr(8'h18, 16'h0060);
        rd(8'h18, d); chk("R9 write while busy sets error, busy kept", d, 16'h0003);
        wait_idle(n);
        rd(8'h1B, d); chk("R9 running read unaffected", d, 16'h00FF);
        read_word(6'd31, d); chk("R9 no mass erase", d, 16'hBEEF);
        wr(8'h18, 16'h0000);
        wr(8'h18, 16'h0033);
        chk("R9 unknown code not started", busy, 1'b0);
        rd(8'h18, d); chk("R9 unknown code sets error", d, 16'h0002);
        wr(8'h18, 16'h0000);
        rd(8'h18, d); chk("R9 cleared", d, 16'h0000);
    endtask

    task automatic t_copy();
        int bytes = 0;
        int bad = 0;
        conv_run = 1'b1;
        wr(8'h18, 16'h00A0);
        while (cram_we && bytes < 1000) begin
            logic [7:0] exp_b;
            exp_b = (bytes % 2 == 0) ? model[bytes/2][15:8] : model[bytes/2][7:0];
            if (cram_addr !== (AW+1)'(bytes) || cram_wdata !== exp_b) begin
                bad++;
                chk("R7 transfer byte", {cram_addr, cram_wdata}, {(AW+1)'(bytes), exp_b});
            end
            bytes++;
            @(negedge clk);
        end
        conv_run = 1'b0;
        chk("R7 transfer length", bytes, 2 * NW);
        chk("R7 transfer contents", bad, 0);
        chk("R2 idle after transfer", busy, 1'b0);
    endtask

    task automatic t_mass();
        logic [15:0] d;
        int n;
        int bad = 0;
        wr(8'h19, 16'h0000);
        cmd(8'h60, n); chk("R2 mass erase duration", n, T_MASS);
        for (int i = 0; i < NW; i++) begin
            read_word(AW'(i), d);
            if (d !== 16'hFFFF) bad++;
        end
        chk("R6 all words erased", bad, 0);
    endtask

    task automatic t_regmap();
        logic [15:0] d;
        wr(8'h1A, 16'hC0DE);
        rd(8'h1A, d); chk("R11 data-in readback", d, 16'hC0DE);
        wr(8'h19, 16'h002D);
        rd(8'h19, d); chk("R11 address readback", d, 16'h002D);
        rd(8'h1B, d);
        wr(8'h1B, 16'h5555);
        begin
            logic [15:0] d2;
            rd(8'h1B, d2); chk("R11 data-out ignores writes", d2, d);
        end
        rd(8'h30, d); chk("R11 unmapped reads zero", d, 16'h0000);
    endtask

    initial begin
        for (int i = 0; i < NW; i++) model[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prog_read();
        t_page();
        t_capture();
        t_conv();
        t_busy_cmd();
        t_copy();
        t_mass();
        t_regmap();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule